// File: doc/BRIEF.md
# Ping-pong strip transposer

This block turns a raster video stream by a quarter turn. Pixels arrive row by row, each marked by a pixel-valid strobe, with a start-of-line and a start-of-frame flag beside it. They are written into one of two banks. Each bank holds a strip of `N` consecutive input lines, and every line has its own small memory. While one bank fills, the other is read out column by column. Each column of a strip leaves as one short output segment. Every segment carries its column number and strip number, so that a frame-buffer writer further down can place it as a row of the rotated image.

The input side cannot be stalled. A pixel that would land in a bank still waiting for or under read-out is dropped, and a sticky overflow pin is raised. The output side is a valid/ready stream. A word is transferred only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the offered word and all of its side-band signals hold still, and no word is ever lost or repeated.

To give every segment a minimum burst length, the block has two build-time variants. Pad mode widens each pixel to a double-width word whose upper half is zero. Duplicate mode sends each pixel twice in a row. With `N` = 32 and 16-bit pixels, both give 128-byte segments. The intended frame is 640 by 480 pixels, which is set through the size parameters.

Top module: `strip_transposer`

## Requirements
- R1: After reset, `out_valid` and `overflow` are both low.
- R2: A completed strip of `N` lines leaves as `LINE_PIX` segments in increasing column order. Segment c carries the pixels at column c of strip lines 0 to N-1, in line order, each taken from its own one-cycle registered line memory.
- R3: In pad mode (`MODE` = MODE_PAD, encoded 1), each pixel is sent once as a 2*PIX_W-bit word. The pixel sits in the low half and the high half is zero.
- R4: In duplicate mode (`MODE` = MODE_DUP, encoded 0), each pixel is sent as two consecutive PIX_W-bit words of equal value.
- R5: `out_last` is high only on the final word of each segment, which in duplicate mode is the second copy of line N-1. `out_col` gives the segment's column (0 to LINE_PIX-1) and `out_strip` gives the strip's position within the frame (0 to FRAME_LINES/N-1).
- R6: `out_eof` is high together with `out_last` on the final word of the last strip of a frame, and on no other word.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data`, `out_last`, `out_col` and `out_strip` keep their values. No word is dropped or duplicated by back-pressure.
- R8: Read-out of a bank starts only after all N lines of its strip have been written. Writing moves on into the other bank, so one strip can be received while the previous one is being read.
- R9: A pixel with `in_sof` high is written at line 0, column 0 of bank A, and the strip count restarts at 0. Partial data written before it never appears on the output.
- R10: A pixel with `in_sol` high is written at column 0 of the current line, which overwrites any stray pixels received on that line before it.
- R11: A pixel aimed at a bank that has not yet been fully read out is dropped and sets `overflow`. The flag stays high until reset, and the bank's stored strip comes out unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the write side and the read side |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel strobe |
| in_sof | input | 1 | Pixel is the first of a frame |
| in_sol | input | 1 | Pixel is the first of a line |
| in_pix | input | PIX_W | Input pixel value |
| out_valid | output | 1 | Output word offered |
| out_ready | input | 1 | Downstream accepts the offered word |
| out_data | output | 2*PIX_W (pad) or PIX_W (duplicate) | Output word |
| out_last | output | 1 | Final word of a segment |
| out_eof | output | 1 | Final word of a frame |
| out_col | output | clog2(LINE_PIX) | Column index of the segment |
| out_strip | output | clog2(FRAME_LINES/N) | Strip index within the frame |
| overflow | output | 1 | Sticky flag: an input pixel was dropped |

## Verification
The bench builds two copies of the block, both with 8-pixel lines, 4-line strips and 8-line frames, so a frame has exactly two strips. One copy is built in pad mode and the other in duplicate mode. The two-strip frame reaches both bank roles and the strip-index wrap in every frame. The short strips make it cheap to hold the read side stalled until both banks are full, which is what drives the overflow path. Running both mode variants on the same input shows that the doubled read-out time of duplicate mode still drains each strip before the next one needs the bank.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  // Burst shaping applied on the output side
  typedef enum logic {
    MODE_DUP = 1'b0,  // every pixel sent twice
    MODE_PAD = 1'b1   // every pixel zero-extended to a double word
  } burst_mode_e;
endpackage

// File: rtl/xpose_line_mem.sv
module xpose_line_mem #(
  parameter int PIX_W = 16,
  parameter int DEPTH = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [PIX_W-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [PIX_W-1:0]         rdata
);
  logic [PIX_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/xpose_writer.sv
module xpose_writer #(
  parameter int LINE_PIX = 32,
  parameter int N        = 32,
  parameter int STRIPS   = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_sof,
  input  logic                       in_sol,
  input  logic [1:0]                 bank_full,
  output logic                       wr_en,
  output logic                       wr_bank,
  output logic [$clog2(N)-1:0]       wr_line,
  output logic [$clog2(LINE_PIX)-1:0] wr_col,
  output logic                       done,
  output logic                       done_bank,
  output logic [$clog2(STRIPS)-1:0]  done_strip,
  output logic                       overflow
);
  localparam int COL_W   = $clog2(LINE_PIX);
  localparam int LINE_W  = $clog2(N);
  localparam int STRIP_W = $clog2(STRIPS);

  logic [COL_W-1:0]   wcol, col_e;
  logic [LINE_W-1:0]  wline, line_e;
  logic               wbank, bank_e;
  logic [STRIP_W-1:0] wstrip, strip_e;
  logic               blocked, line_end, strip_end;

  // Frame and line strobes realign the write position for this very pixel
  always_comb begin
    col_e     = (in_sof || in_sol) ? '0 : wcol;
    line_e    = in_sof ? '0 : wline;
    bank_e    = in_sof ? 1'b0 : wbank;
    strip_e   = in_sof ? '0 : wstrip;
    blocked   = bank_full[bank_e];
    line_end  = (col_e == COL_W'(LINE_PIX - 1));
    strip_end = line_end && (line_e == LINE_W'(N - 1));
  end

  assign wr_en      = in_valid && !blocked;
  assign wr_bank    = bank_e;
  assign wr_line    = line_e;
  assign wr_col     = col_e;
  assign done       = wr_en && strip_end;
  assign done_bank  = bank_e;
  assign done_strip = strip_e;
  assign overflow   = ovf_q;

  logic ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcol   <= '0;
      wline  <= '0;
      wbank  <= 1'b0;
      wstrip <= '0;
      ovf_q  <= 1'b0;
    end else if (in_valid) begin
      if (!blocked) begin
        wcol   <= line_end ? '0 : col_e + 1'b1;
        wline  <= strip_end ? '0 : (line_end ? line_e + 1'b1 : line_e);
        wbank  <= strip_end ? ~bank_e : bank_e;
        wstrip <= !strip_end ? strip_e :
                  (strip_e == STRIP_W'(STRIPS - 1)) ? '0 : strip_e + 1'b1;
      end else begin
        ovf_q  <= 1'b1;
        wcol   <= col_e;
        wline  <= line_e;
        wbank  <= bank_e;
        wstrip <= strip_e;
      end
    end
  end

  // R11: once a pixel has been dropped the flag never falls before reset
  assert_overflow_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

// File: rtl/xpose_reader.sv
module xpose_reader import xpose_pkg::*; #(
  parameter int          PIX_W    = 16,
  parameter int          LINE_PIX = 32,
  parameter int          N        = 32,
  parameter int          STRIPS   = 2,
  parameter burst_mode_e MODE     = MODE_PAD
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  bank_full,
  input  logic                        older,
  input  logic [$clog2(STRIPS)-1:0]   strip_of0,
  input  logic [$clog2(STRIPS)-1:0]   strip_of1,
  output logic [$clog2(LINE_PIX)-1:0] rd_col,
  output logic                        rd_issue,
  output logic                        rd_bank,
  output logic                        s1_bank,
  output logic [$clog2(N)-1:0]        s1_line,
  output logic                        free,
  input  logic [PIX_W-1:0]            mem_q,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [(MODE == MODE_PAD ? 2*PIX_W : PIX_W)-1:0] out_data,
  output logic                        out_last,
  output logic                        out_eof,
  output logic [$clog2(LINE_PIX)-1:0] out_col,
  output logic [$clog2(STRIPS)-1:0]   out_strip
);
  localparam int COL_W   = $clog2(LINE_PIX);
  localparam int LINE_W  = $clog2(N);
  localparam int STRIP_W = $clog2(STRIPS);

  typedef struct packed {
    logic [PIX_W-1:0]   pix;
    logic [COL_W-1:0]   col;
    logic [STRIP_W-1:0] strip;
    logic               last;
    logic               eof;
  } word_t;

  logic               active, rbank, pick;
  logic [COL_W-1:0]   rcol;
  logic [LINE_W-1:0]  rline;
  logic [STRIP_W-1:0] rstrip;
  logic               s1_v, s1_last, s1_eof;
  logic [COL_W-1:0]   s1_col;
  logic [STRIP_W-1:0] s1_strip;
  word_t              e0, e1, new_w;
  logic [1:0]         cnt;
  logic               phase, beat_final, pop, issue, seg_end, bank_end;

  assign beat_final = (MODE == MODE_PAD) ? 1'b1 : phase;
  assign out_valid  = (cnt != 2'd0);
  assign pop        = out_valid && out_ready && beat_final;
  // Credit check: words in the skid pair plus the one in flight from memory
  assign issue      = active && (({1'b0, cnt} + 3'(s1_v)) < (3'd2 + 3'(pop)));
  assign seg_end    = (rline == LINE_W'(N - 1));
  assign bank_end   = seg_end && (rcol == COL_W'(LINE_PIX - 1));
  assign pick       = (bank_full == 2'b11) ? older : bank_full[1];
  assign free       = issue && bank_end;
  assign rd_col     = rcol;
  assign rd_issue   = issue;
  assign rd_bank    = rbank;
  assign new_w      = {mem_q, s1_col, s1_strip, s1_last, s1_eof};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rbank  <= 1'b0;
      rcol   <= '0;
      rline  <= '0;
      rstrip <= '0;
      s1_v   <= 1'b0;
    end else begin
      if (!active && |bank_full) begin
        active <= 1'b1;
        rbank  <= pick;
        rcol   <= '0;
        rline  <= '0;
        rstrip <= pick ? strip_of1 : strip_of0;
      end else if (issue) begin
        if (bank_end) active <= 1'b0;
        if (seg_end) begin
          rline <= '0;
          rcol  <= rcol + 1'b1;
        end else begin
          rline <= rline + 1'b1;
        end
      end
      s1_v <= issue;
    end
  end

  always_ff @(posedge clk) begin
    if (issue) begin
      s1_bank  <= rbank;
      s1_line  <= rline;
      s1_col   <= rcol;
      s1_strip <= rstrip;
      s1_last  <= seg_end;
      s1_eof   <= bank_end && (rstrip == STRIP_W'(STRIPS - 1));
    end
  end

  // Two-entry skid pair; e0 is the word on offer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      phase <= 1'b0;
    end else begin
      case ({s1_v, pop})
        2'b10: begin
          if (cnt == 2'd0) e0 <= new_w; else e1 <= new_w;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          e0  <= e1;
          cnt <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) e0 <= new_w;
          else begin
            e0 <= e1;
            e1 <= new_w;
          end
        end
        default: ;
      endcase
      if (MODE == MODE_DUP && out_valid && out_ready) phase <= ~phase;
    end
  end

  generate
    if (MODE == MODE_PAD) begin : g_pad
      assign out_data = {{PIX_W{1'b0}}, e0.pix};
    end else begin : g_dup
      assign out_data = e0.pix;
    end
  endgenerate

  assign out_last  = e0.last && beat_final;
  assign out_eof   = e0.eof && beat_final;
  assign out_col   = e0.col;
  assign out_strip = e0.strip;

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_col)
      && $stable(out_last) && $stable(out_strip));
  assert_no_skid_overrun_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |-> (cnt != 2'd2 || pop));
  assert_eof_on_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_last);
  assert_second_copy_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    phase |-> out_valid);
endmodule

// File: rtl/strip_transposer.sv
module strip_transposer import xpose_pkg::*; #(
  parameter int          PIX_W       = 16,
  parameter int          LINE_PIX    = 32,
  parameter int          FRAME_LINES = 64,
  parameter int          N           = 32,
  parameter burst_mode_e MODE        = MODE_PAD
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                in_valid,
  input  logic                                in_sof,
  input  logic                                in_sol,
  input  logic [PIX_W-1:0]                    in_pix,
  output logic                                out_valid,
  input  logic                                out_ready,
  output logic [(MODE == MODE_PAD ? 2*PIX_W : PIX_W)-1:0] out_data,
  output logic                                out_last,
  output logic                                out_eof,
  output logic [$clog2(LINE_PIX)-1:0]         out_col,
  output logic [$clog2(FRAME_LINES/N)-1:0]    out_strip,
  output logic                                overflow
);
  localparam int STRIPS  = FRAME_LINES / N;
  localparam int COL_W   = $clog2(LINE_PIX);
  localparam int LINE_W  = $clog2(N);
  localparam int STRIP_W = $clog2(STRIPS);

  logic               wr_en, wr_bank, done, done_bank, last_done;
  logic [LINE_W-1:0]  wr_line, s1_line;
  logic [COL_W-1:0]   wr_col, rd_col;
  logic [STRIP_W-1:0] done_strip, strip_of0, strip_of1;
  logic [1:0]         bank_full;
  logic               rd_issue, rd_bank, s1_bank, free;
  logic [PIX_W-1:0]   mem_q [2][N];
  logic [PIX_W-1:0]   mux_q;

  xpose_writer #(.LINE_PIX(LINE_PIX), .N(N), .STRIPS(STRIPS)) u_writer (
    .clk, .rst_n, .in_valid, .in_sof, .in_sol, .bank_full,
    .wr_en, .wr_bank, .wr_line, .wr_col, .done, .done_bank, .done_strip, .overflow
  );

  // Bank ownership: set when a strip completes, cleared on its final read
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_full <= 2'b00;
      last_done <= 1'b0;
      strip_of0 <= '0;
      strip_of1 <= '0;
    end else begin
      if (done) begin
        bank_full[done_bank] <= 1'b1;
        last_done            <= done_bank;
        if (done_bank) strip_of1 <= done_strip;
        else           strip_of0 <= done_strip;
      end
      if (free) bank_full[rd_bank] <= 1'b0;
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar l = 0; l < N; l++) begin : g_line
      xpose_line_mem #(.PIX_W(PIX_W), .DEPTH(LINE_PIX)) u_mem (
        .clk,
        .we    (wr_en && (wr_bank == 1'(b)) && (wr_line == LINE_W'(l))),
        .waddr (wr_col),
        .wdata (in_pix),
        .raddr (rd_col),
        .rdata (mem_q[b][l])
      );
    end
  end

  assign mux_q = mem_q[s1_bank][s1_line];

  xpose_reader #(.PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .N(N), .STRIPS(STRIPS),
                 .MODE(MODE)) u_reader (
    .clk, .rst_n, .bank_full, .older(~last_done), .strip_of0, .strip_of1,
    .rd_col, .rd_issue, .rd_bank, .s1_bank, .s1_line, .free, .mem_q(mux_q),
    .out_valid, .out_ready, .out_data, .out_last, .out_eof, .out_col, .out_strip
  );

  // R8: a bank is only read while it holds a completed strip
  assert_read_complete_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_issue |-> bank_full[rd_bank]);
  // R11: the writer never touches a bank the reader still owns
  assert_no_write_into_owned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !bank_full[wr_bank]);
endmodule

// File: tb/test_strip_transposer.sv
`timescale 1ns/1ps
module test_strip_transposer;
  localparam int LP = 8, NL = 4, FL = 8, ST = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
  logic [15:0] in_pix = '0;
  logic rdy_p = 1'b0, rdy_d = 1'b0;
  logic vp, vd, lastp, lastd, eofp, eofd, ovp, ovd, stp, std;
  logic [31:0] dp;
  logic [15:0] dd;
  logic [2:0] colp, cold;

  strip_transposer #(.PIX_W(16), .LINE_PIX(LP), .FRAME_LINES(FL), .N(NL),
                     .MODE(xpose_pkg::MODE_PAD)) i_strip_transposer (
    .clk, .rst_n, .in_valid, .in_sof, .in_sol, .in_pix,
    .out_valid(vp), .out_ready(rdy_p), .out_data(dp), .out_last(lastp),
    .out_eof(eofp), .out_col(colp), .out_strip(stp), .overflow(ovp));

  strip_transposer #(.PIX_W(16), .LINE_PIX(LP), .FRAME_LINES(FL), .N(NL),
                     .MODE(xpose_pkg::MODE_DUP)) i_strip_transposer_dup (
    .clk, .rst_n, .in_valid, .in_sof, .in_sol, .in_pix,
    .out_valid(vd), .out_ready(rdy_d), .out_data(dd), .out_last(lastd),
    .out_eof(eofd), .out_col(cold), .out_strip(std), .overflow(ovd));

  int n_chk = 0, n_fail = 0, cyc = 0, rdy_mode = 0;
  int kp = 0, fp = 0, kd = 0, fd = 0;

  function automatic logic [15:0] pix(int f, int r, int c);
    return {f[3:0], r[5:0], c[5:0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Ready patterns change just after the edge; outputs are sampled at negedge
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
    #1;
    rdy_p = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 5) != 2 && (cyc % 7) != 0);
    rdy_d = (rdy_mode == 0) || (rdy_mode == 1 && (cyc % 3) != 0);
  end

  logic pv_q = 0, pr_q = 0, dv_q = 0, dr_q = 0;
  logic [31:0] pd_q;
  logic [15:0] dd_q;

  always @(negedge clk) if (rst_n) begin
    int s, rem, c, l;
    if (pv_q && !pr_q) begin
      chk("R7 pad valid held", vp, 1);
      chk("R7 pad data held", dp, pd_q);
    end
    if (vp && rdy_p) begin
      s = kp / (LP*NL); rem = kp % (LP*NL); c = rem / NL; l = rem % NL;
      chk("R2 R3 pad word", dp, {16'h0, pix(fp, s*NL + l, c)});
      chk("R5 pad last", lastp, l == NL-1);
      chk("R5 pad col", colp, c);
      chk("R5 pad strip", stp, s);
      chk("R6 pad eof", eofp, l == NL-1 && c == LP-1 && s == ST-1);
      kp++;
      if (kp == LP*FL) begin kp = 0; fp++; end
    end
    pv_q = vp; pr_q = rdy_p; pd_q = dp;
  end

  always @(negedge clk) if (rst_n) begin
    int s, rem, c, j;
    if (dv_q && !dr_q) begin
      chk("R7 dup valid held", vd, 1);
      chk("R7 dup data held", dd, dd_q);
    end
    if (vd && rdy_d) begin
      s = kd / (2*LP*NL); rem = kd % (2*LP*NL); c = rem / (2*NL); j = rem % (2*NL);
      chk("R2 R4 dup word", dd, pix(fd, s*NL + j/2, c));
      chk("R5 dup last", lastd, j == 2*NL-1);
      chk("R5 dup col", cold, c);
      chk("R5 dup strip", std, s);
      chk("R6 dup eof", eofd, j == 2*NL-1 && c == LP-1 && s == ST-1);
      kd++;
      if (kd == 2*LP*FL) begin kd = 0; fd++; end
    end
    dv_q = vd; dr_q = rdy_d; dd_q = dd;
  end

  task automatic drive(logic v, logic sof, logic sol, logic [15:0] p);
    @(posedge clk); #1;
    in_valid = v; in_sof = sof; in_sol = sol; in_pix = p;
  endtask

  task automatic idle(int n);
    repeat (n) drive(0, 0, 0, '0);
  endtask

  // probe: stop before the final pixel of strip 0 and look at the outputs
  task automatic feed_frame(int f, int gap, bit glitch, int rows, bit probe);
    for (int r = 0; r < rows; r++) begin
      if (glitch && r == 1)
        for (int g = 0; g < 3; g++) drive(1, 0, 0, 16'hFFFF);
      for (int c = 0; c < LP; c++) begin
        if (probe && r == NL-1 && c == LP-1) begin
          idle(12);
          chk("R8 pad no read before strip full", vp, 0);
          chk("R8 dup no read before strip full", vd, 0);
        end
        drive(1, r == 0 && c == 0, c == 0, pix(f, r, c));
        if (probe && r == NL-1 && c == LP-1) begin
          idle(6);
          chk("R8 pad read starts on full strip", vp, 1);
          chk("R8 dup read starts on full strip", vd, 1);
        end
        if (gap > 0) idle(gap);
      end
    end
    idle(1);
  endtask

  task automatic wait_frames(int target, logic exp_ovf);
    wait (fp >= target && fd >= target);
    idle(20);
    chk("R2 pad frame count", fp, target);
    chk("R2 dup frame count", fd, target);
    chk("R11 pad overflow flag", ovp, exp_ovf);
    chk("R11 dup overflow flag", ovd, exp_ovf);
  endtask

  task automatic test_reset();
    idle(4);
    chk("R1 pad valid after reset", vp, 0);
    chk("R1 dup valid after reset", vd, 0);
    chk("R1 pad overflow after reset", ovp, 0);
    chk("R1 dup overflow after reset", ovd, 0);
  endtask

  task automatic test_plain();          // R2 R3 R4 with ready held high
    rdy_mode = 0;
    feed_frame(0, 0, 0, FL, 0);
    wait_frames(1, 0);
  endtask

  task automatic test_backpressure();   // R7 with irregular ready
    rdy_mode = 1;
    feed_frame(1, 0, 0, FL, 0);
    wait_frames(2, 0);
  endtask

  task automatic test_strip_gate();     // R8 with gaps between pixels
    rdy_mode = 0;
    feed_frame(2, 2, 0, FL, 1);
    wait_frames(3, 0);
  endtask

  task automatic test_sol();            // R10 stray pixels before a line start
    rdy_mode = 0;
    feed_frame(3, 0, 1, FL, 0);
    wait_frames(4, 0);
  endtask

  task automatic test_sof();            // R9 partial frame abandoned
    rdy_mode = 0;
    feed_frame(9, 0, 0, 2, 0);
    idle(10);
    chk("R9 pad nothing from partial strip", vp, 0);
    feed_frame(4, 0, 0, FL, 0);
    wait_frames(5, 0);
  endtask

  task automatic test_overflow();       // R11 both banks held, extra line dropped
    rdy_mode = 2;
    feed_frame(5, 0, 0, FL, 0);
    for (int c = 0; c < LP; c++) drive(1, 0, c == 0, pix(6, 0, c));
    idle(10);
    chk("R11 pad overflow set", ovp, 1);
    chk("R11 dup overflow set", ovd, 1);
    chk("R11 pad head word intact", dp, {16'h0, pix(5, 0, 0)});
    chk("R11 dup head word intact", dd, pix(5, 0, 0));
    rdy_mode = 0;
    wait_frames(6, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    test_reset();
    test_plain();
    test_backpressure();
    test_strip_gate();
    test_sol();
    test_sof();
    test_overflow();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule